// File: doc/BRIEF.md
# Subwoofer Bass Management Path

This block forms the sample for the low-frequency output channel ahead of its filter chain. For every input sample it builds one of two pre-volume values. The first is a bass-managed sum: the subwoofer channel raised by a fixed +10 dB, with the five full-range main channels then added at unity gain. The second is the average of the left and right downmix outputs, which another block computes and supplies.

A select bit chooses between the two. A signed volume coefficient then scales the chosen value, and the result is clipped to the sample width. Because the bass-managed sum still carries full-range content from the main channels, the output feeds two cascaded second-order low-pass stages outside this block. The first of those stages can run plain or with gain compensation.

Processing is triggered by a one-cycle sample strobe. The result appears, with its own one-cycle valid pulse, exactly two clocks later. The pipeline accepts a new strobe on every clock.

Top module: `sub_bass_path`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `smp_o` is 0.
- R2: Each `strobe_i` pulse produces exactly one `valid_o` pulse two clock edges later, and `valid_o` is never high otherwise. Back-to-back strobes are accepted.
- R3: With `src_sel_i` = 0, the pre-volume value is floor(sub × 0x194C583 / 2^23) + ch0 + ch1 + ch2 + ch3 + ch4. Here `ch_i[5]` (bits 143:120) is the subwoofer and `ch_i[k]` (bits 24k+23:24k) is main channel k. All samples are signed 24-bit.
- R4: With `src_sel_i` = 1, the pre-volume value is `dmx_avg_i`, a signed 24-bit value.
- R5: The output is floor(pre × vol / 2^23), where `vol_i` is signed 3.23. The value 0x800000 is unity, 0 mutes, and negative values invert.
- R6: Clipping to the range [-2^23, 2^23-1] happens only after the volume multiply. A sum that overflows 24 bits but is brought back into range by the volume passes through unclipped.
- R7: `smp_o` holds its value on every cycle in which `valid_o` is low.
- R8: All inputs are sampled only on the `strobe_i` cycle. Changes on the following cycles do not affect that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Sample strobe, one cycle per sample |
| ch_i | input | 144 | Six signed channel samples; index 5 is the subwoofer |
| dmx_avg_i | input | 24 | Signed downmix average (L'+R')/2 |
| src_sel_i | input | 1 | 0 = bass-managed sum, 1 = downmix average |
| vol_i | input | 26 | Signed 3.23 volume coefficient |
| smp_o | output | 24 | Signed pre-filter sample |
| valid_o | output | 1 | Sample valid, two clocks after the strobe |

## Verification
The bench builds the block with its default parameters: 24-bit samples, 26-bit coefficients and five main channels.

These values make the internal sum reach roughly 2^26 when every channel is at full scale. That range lets the bench hit clipping in both directions, and also a large sum that a small volume brings back into range without clipping. The signed 26-bit coefficient also allows negative and zero volumes, and the floor behaviour on negative boosted samples is checked.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  localparam int unsigned SBP_DATA_W = 24;
  localparam int unsigned SBP_COEF_W = 26;
  localparam int unsigned SBP_FRAC_W = 23;
  localparam int unsigned SBP_NUM_MAIN = 5;
  // +10 dB in signed 3.23
  localparam logic [SBP_COEF_W-1:0] SBP_BOOST = 26'h194C583;
endpackage

// File: rtl/sbp_bass_sum.sv
module sbp_bass_sum #(
  parameter int unsigned DATA_W   = 24,
  parameter int unsigned COEF_W   = 26,
  parameter int unsigned FRAC_W   = 23,
  parameter int unsigned NUM_MAIN = 5,
  parameter int unsigned ACC_W    = 30,
  parameter logic [COEF_W-1:0] BOOST = '0
) (
  input  logic [NUM_MAIN:0][DATA_W-1:0] ch_i,
  output logic signed [ACC_W-1:0]       sum_o
);
  localparam int unsigned PW = DATA_W + COEF_W;

  logic signed [PW-1:0]    boost_prod;
  logic signed [ACC_W-1:0] part [NUM_MAIN+1];

  assign boost_prod = $signed(ch_i[NUM_MAIN]) * $signed(BOOST);
  assign part[0]    = ACC_W'(boost_prod >>> FRAC_W);

  for (genvar g = 0; g < NUM_MAIN; g++) begin : g_main
    assign part[g+1] = part[g] + ACC_W'($signed(ch_i[g]));
  end

  assign sum_o = part[NUM_MAIN];
endmodule

// File: rtl/sbp_vol_sat.sv
module sbp_vol_sat #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned COEF_W = 26,
  parameter int unsigned FRAC_W = 23,
  parameter int unsigned ACC_W  = 30
) (
  input  logic signed [ACC_W-1:0]  acc_i,
  input  logic signed [COEF_W-1:0] vol_i,
  output logic signed [DATA_W-1:0] smp_o
);
  localparam int unsigned PW = ACC_W + COEF_W;
  localparam logic signed [PW-1:0] MAX_V = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PW-1:0] MIN_V = {{(PW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;

  assign prod   = acc_i * vol_i;
  assign scaled = prod >>> FRAC_W;

  always_comb begin
    if (scaled > MAX_V)      smp_o = DATA_W'(MAX_V);
    else if (scaled < MIN_V) smp_o = DATA_W'(MIN_V);
    else                     smp_o = DATA_W'(scaled);
  end
endmodule

// File: rtl/sub_bass_path.sv
module sub_bass_path
  import sbp_pkg::*;
#(
  parameter int unsigned DATA_W   = SBP_DATA_W,
  parameter int unsigned COEF_W   = SBP_COEF_W,
  parameter int unsigned FRAC_W   = SBP_FRAC_W,
  parameter int unsigned NUM_MAIN = SBP_NUM_MAIN,
  parameter logic [COEF_W-1:0] BOOST = SBP_BOOST
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          strobe_i,
  input  logic [NUM_MAIN:0][DATA_W-1:0] ch_i,
  input  logic [DATA_W-1:0]             dmx_avg_i,
  input  logic                          src_sel_i,
  input  logic [COEF_W-1:0]             vol_i,
  output logic [DATA_W-1:0]             smp_o,
  output logic                          valid_o
);
  // headroom: boosted sub plus all mains at full scale
  localparam int unsigned ACC_W = DATA_W + COEF_W - FRAC_W + $clog2(NUM_MAIN + 1);

  logic signed [ACC_W-1:0]  bass_sum;
  logic signed [ACC_W-1:0]  pre_sel;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [COEF_W-1:0] vol_q;
  logic                     v1_q;
  logic signed [DATA_W-1:0] gained;
  logic [DATA_W-1:0]        smp_q;
  logic                     valid_q;

  sbp_bass_sum #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W),
    .NUM_MAIN(NUM_MAIN), .ACC_W(ACC_W), .BOOST(BOOST)
  ) u_sum (
    .ch_i (ch_i),
    .sum_o(bass_sum)
  );

  assign pre_sel = src_sel_i ? ACC_W'($signed(dmx_avg_i)) : bass_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      vol_q <= '0;
      v1_q  <= 1'b0;
    end else begin
      v1_q <= strobe_i;
      if (strobe_i) begin
        acc_q <= pre_sel;
        vol_q <= $signed(vol_i);
      end
    end
  end

  sbp_vol_sat #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)
  ) u_vol (
    .acc_i(acc_q),
    .vol_i(vol_q),
    .smp_o(gained)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= v1_q;
      if (v1_q) smp_q <= gained;
    end
  end

  assign smp_o   = smp_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/sbp_checker.sv
module sbp_checker #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned COEF_W = 26,
  parameter int unsigned FRAC_W = 23
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_i,
  input logic [DATA_W-1:0] dmx_avg_i,
  input logic              src_sel_i,
  input logic [COEF_W-1:0] vol_i,
  input logic [DATA_W-1:0] smp_o,
  input logic              valid_o
);
  localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC_W;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_idle: assert (!valid_o && smp_o == '0);
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |-> ##2 valid_o);

  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(strobe_i, 2));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(smp_o));

  a_r4_dmx_unity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(src_sel_i, 2) && $past(vol_i, 2) == UNITY)
      |-> smp_o == $past(dmx_avg_i, 2));

  a_r5_mute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(vol_i, 2) == '0) |-> smp_o == '0);
endmodule

bind sub_bass_path sbp_checker #(
  .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)
) u_sbp_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .strobe_i (strobe_i),
  .dmx_avg_i(dmx_avg_i),
  .src_sel_i(src_sel_i),
  .vol_i    (vol_i),
  .smp_o    (smp_o),
  .valid_o  (valid_o)
);

// File: tb/sub_bass_path_bench.sv
module sub_bass_path_bench;
  localparam longint BOOST_C = 64'sh194C583;
  localparam longint UNITY   = 64'sh800000;
  localparam longint SMAX    = 64'sh7FFFFF;
  localparam longint SMIN    = -64'sh800000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              strobe = 1'b0;
  logic [5:0][23:0]  ch = '0;
  logic [23:0]       dmx = '0;
  logic              sel = 1'b0;
  logic [25:0]       vol = '0;
  logic [23:0]       smp;
  logic              valid;

  int checks = 0;
  int fails  = 0;
  longint cyc = 0;

  longint exp_q [$];
  longint cyc_q [$];
  string  tag_q [$];

  sub_bass_path u_sub_bass_path (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .ch_i(ch),
    .dmx_avg_i(dmx), .src_sel_i(sel), .vol_i(vol),
    .smp_o(smp), .valid_o(valid)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint model(input longint c[6], input longint avg,
                                   input bit s, input longint v);
    longint acc, p;
    if (s) acc = avg;
    else begin
      acc = (c[5] * BOOST_C) >>> 23;
      for (int k = 0; k < 5; k++) acc += c[k];
    end
    p = (acc * v) >>> 23;
    if (p > SMAX) p = SMAX;
    if (p < SMIN) p = SMIN;
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic drive_item(input longint c[6], input longint avg, input bit s,
                            input longint v, input string tag);
    @(negedge clk);
    for (int k = 0; k < 6; k++) ch[k] = c[k][23:0];
    dmx    = avg[23:0];
    sel    = s;
    vol    = v[25:0];
    strobe = 1'b1;
    exp_q.push_back(model(c, avg, s, v));
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  // R8: scramble every input once the strobe is gone
  task automatic idle(input int n);
    @(negedge clk);
    strobe = 1'b0;
    for (int k = 0; k < 6; k++) ch[k] = 24'h5A5A5A ^ 24'(k);
    dmx = 24'h3C3C3C;
    sel = ~sel;
    vol = 26'h1234567;
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected valid", 1, 0);
      end else begin
        longint e, c0;
        string t;
        e  = exp_q.pop_front();
        c0 = cyc_q.pop_front();
        t  = tag_q.pop_front();
        check($signed(smp) == e, t, longint'($signed(smp)), e);
        check(cyc - c0 == 2, "R2 latency", cyc - c0, 2);
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #2_000_000;
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    longint c[6];
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R1 valid in reset", longint'(valid), 0);
    check(smp == '0, "R1 smp in reset", longint'(smp), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R3 bass sum, unity volume
    c = '{1000, 2000, 3000, 4000, 5000, 64'sh100000};
    drive_item(c, 0, 1'b0, UNITY, "R3 bass sum");
    idle(3);
    // R3 negative sub floors downward
    c = '{0, 0, 0, 0, 0, -3};
    drive_item(c, 0, 1'b0, UNITY, "R3 negative floor");
    idle(3);
    c = '{-70000, 12345, -1, 400000, -250000, -600000};
    drive_item(c, 0, 1'b0, UNITY, "R3 mixed signs");
    idle(3);
    // R4 downmix average
    c = '{7, 7, 7, 7, 7, 7};
    drive_item(c, -123456, 1'b1, UNITY, "R4 downmix");
    idle(3);
    // R5 half, mute, negative volume
    drive_item(c, 3000001, 1'b1, 64'sh400000, "R5 half volume");
    idle(3);
    c = '{64'sh7FFFFF, 64'sh7FFFFF, 64'sh7FFFFF, 64'sh7FFFFF, 64'sh7FFFFF, 64'sh7FFFFF};
    drive_item(c, 0, 1'b0, 0, "R5 mute");
    idle(3);
    c = '{100, -200, 300, -400, 500, 64'sh20000};
    drive_item(c, 0, 1'b0, -UNITY, "R5 inverted volume");
    idle(3);
    // R6 clip both ways, and no clip before volume
    c = '{64'sh7FFFFF, 64'sh7FFFFF, 64'sh7FFFFF, 64'sh7FFFFF, 64'sh7FFFFF, 64'sh7FFFFF};
    drive_item(c, 0, 1'b0, UNITY, "R6 positive clip");
    idle(3);
    c = '{SMIN, SMIN, SMIN, SMIN, SMIN, SMIN};
    drive_item(c, 0, 1'b0, UNITY, "R6 negative clip");
    idle(3);
    c = '{64'sh7FFFFF, 64'sh7FFFFF, 64'sh7FFFFF, 64'sh7FFFFF, 64'sh7FFFFF, 64'sh7FFFFF};
    drive_item(c, 0, 1'b0, 64'sh0C0000, "R6 wide sum unclipped");
    idle(3);
    check(smp == 24'(model(c, 0, 1'b0, 64'sh0C0000)), "R7 hold after idle",
          longint'($signed(smp)), model(c, 0, 1'b0, 64'sh0C0000));
    // R2 back-to-back strobes
    c = '{1, 2, 3, 4, 5, 6};
    drive_item(c, 0, 1'b0, UNITY, "R2 burst a");
    drive_item(c, 999, 1'b1, UNITY, "R2 burst b");
    c = '{-10, -20, -30, -40, -50, 64'sh40000};
    drive_item(c, 0, 1'b0, 64'sh600000, "R2 burst c");
    idle(6);
    check(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule